// File: doc/BRIEF.md
# Receive Acceptance Slot Selector

This block picks the message slot that keeps a received CAN frame. The frame has already passed its bit-level checks. The containing controller gives the block the frame's identifier, format flag, data length and first two data bytes, and raises a one-cycle start pulse. One clock later the block reports whether any slot accepted the frame and, if so, which one. Copying the payload into the chosen slot is left to the surrounding logic.

There are fifteen slots, numbered 1 to 15. Each slot carries a ready flag, a transmit flag, an arbitration value and two mode bits. The first mode bit chooses an exact identifier comparison or a comparison through an identifier mask. The second mode bit adds a filter on the first two data bytes, using two shared media arbitration bytes and two media masks. Slots 1 to 14 share one identifier mask. Slot 15 has its own mask and always acts as a receiver. All slots are evaluated in parallel, and the lowest-numbered slot that passes wins.

Top module: `can_accept_select`

## Requirements
- R1: When `start` is high at a rising edge, `res_valid` is high for exactly the following cycle. When `start` is low, `res_valid` is low in the next cycle.
- R2: After a cycle with `rst` high, `res_valid`, `res_hit` and `res_slot` are all 0.
- R3: A slot whose `slot_rdy` bit is 0 never wins. Slot k uses bit k-1 of every per-slot vector.
- R4: When several slots pass, `res_slot` reports the lowest-numbered one (1 to 15).
- R5: With `frm_ext`=0 only identifier bits [10:0] are compared, and bits [28:11] of the identifier and the arbitration value are ignored. With `frm_ext`=1 all 29 bits are compared.
- R6: With the slot's `slot_masked` bit at 0, every compared bit must be equal. With it at 1, a bit is compared only where the mask holds a 1. Slots 1 to 14 use `id_mask`, and slot 15 uses `last_mask`.
- R7: With the slot's `slot_dfilt` bit at 1, the slot also needs `frm_dlc` >= 2, `frm_b0` equal to `med_arb0` on the bits set in `med_mask0`, and `frm_b1` equal to `med_arb1` on the bits set in `med_mask1`. With the bit at 0, the data bytes and the length are ignored.
- R8: A slot among 1 to 14 whose `slot_tx` bit is 1 never wins. Bit 14 of `slot_tx` (slot 15) has no effect.
- R9: When no slot passes, `res_hit` is 0 and `res_slot` is 0 in the result cycle.
- R10: Frame and configuration inputs are sampled only in the start cycle. `res_hit` and `res_slot` hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Evaluate the presented frame this cycle |
| frm_ext | input | 1 | 1 = 29-bit identifier, 0 = 11-bit |
| frm_id | input | 29 | Frame identifier; standard IDs in bits [10:0] |
| frm_dlc | input | 4 | Number of data bytes in the frame |
| frm_b0 | input | 8 | First data byte |
| frm_b1 | input | 8 | Second data byte |
| slot_rdy | input | 15 | Per-slot enable |
| slot_tx | input | 15 | Per-slot transmit mode (bit 14 ignored) |
| slot_masked | input | 15 | Per-slot masked identifier compare |
| slot_dfilt | input | 15 | Per-slot data-byte filter enable |
| slot_arb | input | 435 | Arbitration values, slot k at bits [29k-1 -: 29] |
| id_mask | input | 29 | Identifier mask for slots 1 to 14 |
| last_mask | input | 29 | Identifier mask for slot 15 |
| med_arb0 | input | 8 | Media arbitration byte for data byte 0 |
| med_arb1 | input | 8 | Media arbitration byte for data byte 1 |
| med_mask0 | input | 8 | Media mask for data byte 0 |
| med_mask1 | input | 8 | Media mask for data byte 1 |
| res_valid | output | 1 | Result strobe, one cycle after start |
| res_hit | output | 1 | A slot accepted the frame |
| res_slot | output | 4 | Winning slot 1 to 15, or 0 |

## Verification
Identifier acceptance and the data-byte filter can settle in the same evaluation with opposite outcomes on different slots. This is provoked by giving a low slot a matching identifier but a failing byte pattern or a short length, while a higher slot with no data filter also matches the identifier. The result is judged correct only if the higher slot is reported. Priority and eligibility are tested together in the same way: a lower matching slot is disabled or set to transmit, and the next eligible slot must be chosen.

// File: rtl/can_acc_pkg.sv
package can_acc_pkg;
  localparam int ACC_EXT_W  = 29;
  localparam int ACC_STD_W  = 11;
  localparam int ACC_BYTE_W = 8;
  localparam int ACC_DLC_W  = 4;
  localparam int ACC_SLOTS  = 15;
  localparam int ACC_MIN_BYTES = 2;
endpackage

// File: rtl/can_slot_match.sv
module can_slot_match
  import can_acc_pkg::*;
#(
  parameter int EXT_W  = ACC_EXT_W,
  parameter int STD_W  = ACC_STD_W,
  parameter int BYTE_W = ACC_BYTE_W,
  parameter int DLC_W  = ACC_DLC_W,
  parameter int MIN_BYTES = ACC_MIN_BYTES
) (
  input  logic              frm_ext,
  input  logic [EXT_W-1:0]  frm_id,
  input  logic [DLC_W-1:0]  frm_dlc,
  input  logic [BYTE_W-1:0] frm_b0,
  input  logic [BYTE_W-1:0] frm_b1,
  input  logic [EXT_W-1:0]  arb,
  input  logic [EXT_W-1:0]  mask,
  input  logic              use_mask,
  input  logic              use_data,
  input  logic [BYTE_W-1:0] med_arb0,
  input  logic [BYTE_W-1:0] med_arb1,
  input  logic [BYTE_W-1:0] med_mask0,
  input  logic [BYTE_W-1:0] med_mask1,
  output logic              pass
);
  localparam logic [EXT_W-1:0] STD_FIELD = {{(EXT_W-STD_W){1'b0}}, {STD_W{1'b1}}};
  localparam logic [DLC_W-1:0] MIN_LEN   = DLC_W'(MIN_BYTES);

  logic [EXT_W-1:0] fmt_sel;
  logic [EXT_W-1:0] cmp_sel;
  logic             id_ok;
  logic             len_ok;
  logic             bytes_ok;
  logic             data_ok;

  always_comb begin
    fmt_sel  = frm_ext ? {EXT_W{1'b1}} : STD_FIELD;
    cmp_sel  = use_mask ? (fmt_sel & mask) : fmt_sel;
    id_ok    = ((frm_id ^ arb) & cmp_sel) == '0;
    len_ok   = frm_dlc >= MIN_LEN;
    bytes_ok = (((frm_b0 ^ med_arb0) & med_mask0) == '0) &&
               (((frm_b1 ^ med_arb1) & med_mask1) == '0);
    data_ok  = !use_data || (len_ok && bytes_ok);
    pass     = id_ok && data_ok;
  end
endmodule

// File: rtl/can_first_pick.sv
module can_first_pick #(
  parameter int N     = 15,
  parameter int IDX_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     req,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i + 1);
    end
    hit = |req;
  end
endmodule

// File: rtl/can_accept_select.sv
module can_accept_select
  import can_acc_pkg::*;
#(
  parameter int NUM_SLOTS = ACC_SLOTS,
  parameter int EXT_W     = ACC_EXT_W,
  parameter int STD_W     = ACC_STD_W,
  parameter int BYTE_W    = ACC_BYTE_W,
  parameter int DLC_W     = ACC_DLC_W,
  parameter int IDX_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic                       frm_ext,
  input  logic [EXT_W-1:0]           frm_id,
  input  logic [DLC_W-1:0]           frm_dlc,
  input  logic [BYTE_W-1:0]          frm_b0,
  input  logic [BYTE_W-1:0]          frm_b1,
  input  logic [NUM_SLOTS-1:0]       slot_rdy,
  input  logic [NUM_SLOTS-1:0]       slot_tx,
  input  logic [NUM_SLOTS-1:0]       slot_masked,
  input  logic [NUM_SLOTS-1:0]       slot_dfilt,
  input  logic [NUM_SLOTS*EXT_W-1:0] slot_arb,
  input  logic [EXT_W-1:0]           id_mask,
  input  logic [EXT_W-1:0]           last_mask,
  input  logic [BYTE_W-1:0]          med_arb0,
  input  logic [BYTE_W-1:0]          med_arb1,
  input  logic [BYTE_W-1:0]          med_mask0,
  input  logic [BYTE_W-1:0]          med_mask1,
  output logic                       res_valid,
  output logic                       res_hit,
  output logic [IDX_W-1:0]           res_slot
);
  localparam int LAST = NUM_SLOTS - 1;

  logic [NUM_SLOTS-1:0] pass;
  logic [NUM_SLOTS-1:0] eligible;
  logic [NUM_SLOTS-1:0] req;
  logic                 pick_hit;
  logic [IDX_W-1:0]     pick_idx;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [EXT_W-1:0] sel_mask;
    if (s == LAST) begin : g_rx_only
      assign sel_mask    = last_mask;
      assign eligible[s] = slot_rdy[s];
    end else begin : g_rx_tx
      assign sel_mask    = id_mask;
      assign eligible[s] = slot_rdy[s] & ~slot_tx[s];
    end

    can_slot_match #(
      .EXT_W (EXT_W),
      .STD_W (STD_W),
      .BYTE_W(BYTE_W),
      .DLC_W (DLC_W)
    ) u_match (
      .frm_ext  (frm_ext),
      .frm_id   (frm_id),
      .frm_dlc  (frm_dlc),
      .frm_b0   (frm_b0),
      .frm_b1   (frm_b1),
      .arb      (slot_arb[s*EXT_W +: EXT_W]),
      .mask     (sel_mask),
      .use_mask (slot_masked[s]),
      .use_data (slot_dfilt[s]),
      .med_arb0 (med_arb0),
      .med_arb1 (med_arb1),
      .med_mask0(med_mask0),
      .med_mask1(med_mask1),
      .pass     (pass[s])
    );
  end

  assign req = pass & eligible;

  can_first_pick #(
    .N    (NUM_SLOTS),
    .IDX_W(IDX_W)
  ) u_pick (
    .req(req),
    .hit(pick_hit),
    .idx(pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_slot  <= '0;
    end else begin
      res_valid <= start;
      if (start) begin
        res_hit  <= pick_hit;
        res_slot <= pick_idx;
      end
    end
  end
endmodule

// File: rtl/can_acc_chk.sv
module can_acc_chk #(
  parameter int NUM_SLOTS = 15,
  parameter int IDX_W     = $clog2(NUM_SLOTS + 1)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 start,
  input logic [NUM_SLOTS-1:0] slot_rdy,
  input logic [NUM_SLOTS-1:0] slot_tx,
  input logic                 res_valid,
  input logic                 res_hit,
  input logic [IDX_W-1:0]     res_slot
);
  logic [NUM_SLOTS-1:0] rdy_q;
  logic [NUM_SLOTS-1:0] tx_q;
  logic [IDX_W-1:0]     pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q <= '0;
      tx_q  <= '0;
    end else if (start) begin
      rdy_q <= slot_rdy;
      tx_q  <= slot_tx;
    end
  end

  assign pos = res_slot - IDX_W'(1);

  // R1
  valid_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> res_valid);
  // R1
  valid_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> !res_valid);
  // R2
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!res_valid && !res_hit && res_slot == '0));
  // R3
  winner_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_hit) |-> (res_slot != '0 && res_slot <= IDX_W'(NUM_SLOTS) && rdy_q[pos]));
  // R8
  winner_not_tx_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_hit && res_slot < IDX_W'(NUM_SLOTS)) |-> !tx_q[pos]);
  // R9
  miss_zero_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> res_slot == '0);
  // R10
  result_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(res_hit) && $stable(res_slot)));
endmodule

bind can_accept_select can_acc_chk #(
  .NUM_SLOTS(NUM_SLOTS),
  .IDX_W    (IDX_W)
) u_acc_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .slot_rdy (slot_rdy),
  .slot_tx  (slot_tx),
  .res_valid(res_valid),
  .res_hit  (res_hit),
  .res_slot (res_slot)
);

// File: tb/tb_can_accept_select.sv
`timescale 1ns/100ps
module tb_can_accept_select;
  logic              clk = 1'b0;
  logic              rst;
  logic              start;
  logic              frm_ext;
  logic [28:0]       frm_id;
  logic [3:0]        frm_dlc;
  logic [7:0]        frm_b0, frm_b1;
  logic [14:0]       slot_rdy, slot_tx, slot_masked, slot_dfilt;
  logic [14:0][28:0] arb_a;
  logic [28:0]       id_mask, last_mask;
  logic [7:0]        med_arb0, med_arb1, med_mask0, med_mask1;
  logic              res_valid, res_hit;
  logic [3:0]        res_slot;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  can_accept_select dut (
    .clk(clk), .rst(rst), .start(start),
    .frm_ext(frm_ext), .frm_id(frm_id), .frm_dlc(frm_dlc),
    .frm_b0(frm_b0), .frm_b1(frm_b1),
    .slot_rdy(slot_rdy), .slot_tx(slot_tx),
    .slot_masked(slot_masked), .slot_dfilt(slot_dfilt),
    .slot_arb(arb_a), .id_mask(id_mask), .last_mask(last_mask),
    .med_arb0(med_arb0), .med_arb1(med_arb1),
    .med_mask0(med_mask0), .med_mask1(med_mask1),
    .res_valid(res_valid), .res_hit(res_hit), .res_slot(res_slot)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_cfg();
    start = 0; frm_ext = 0; frm_id = '0; frm_dlc = 4'd8;
    frm_b0 = '0; frm_b1 = '0;
    slot_rdy = '0; slot_tx = '0; slot_masked = '0; slot_dfilt = '0;
    arb_a = '0; id_mask = '1; last_mask = '1;
    med_arb0 = '0; med_arb1 = '0; med_mask0 = '0; med_mask1 = '0;
  endtask

  // Pulses start, then samples the result one cycle later at the falling edge.
  task automatic run(input string tag, input int exp_slot);
    @(negedge clk) start = 1;
    @(negedge clk);
    check({tag, " valid"}, int'(res_valid), 1);
    check({tag, " hit"}, int'(res_hit), (exp_slot != 0) ? 1 : 0);
    check({tag, " slot"}, int'(res_slot), exp_slot);
    start = 0;
  endtask

  task automatic t_reset();
    clear_cfg();
    rst = 1;
    repeat (3) @(negedge clk);
    check("R2 valid", int'(res_valid), 0);
    check("R2 hit", int'(res_hit), 0);
    check("R2 slot", int'(res_slot), 0);
    rst = 0;
    slot_rdy[0] = 1;
    repeat (2) @(negedge clk);
    check("R1 no start", int'(res_valid), 0);
  endtask

  task automatic t_exact_std();
    clear_cfg();
    slot_rdy[2] = 1; arb_a[2] = 29'h123;
    frm_id = 29'h123;       run("R5 std exact", 3);
    frm_id = 29'h124;       run("R9 no match", 0);
    frm_id = 29'h1000123;   run("R5 std upper ignored", 3);
  endtask

  task automatic t_priority();
    clear_cfg();
    slot_rdy[3] = 1; slot_rdy[6] = 1; slot_rdy[8] = 1;
    arb_a[3] = 29'h55; arb_a[6] = 29'h55; arb_a[8] = 29'h55;
    frm_id = 29'h55;        run("R4 lowest wins", 4);
    slot_rdy[3] = 0;        run("R3 disabled skipped", 7);
    slot_tx[6] = 1;         run("R8 tx skipped", 9);
    slot_rdy = 15'h4000; arb_a[14] = 29'h55; slot_tx[14] = 1;
    run("R8 slot15 tx ignored", 15);
  endtask

  task automatic t_masked();
    clear_cfg();
    id_mask = 29'h7F0;
    slot_rdy[1] = 1; slot_masked[1] = 1; arb_a[1] = 29'h120;
    frm_id = 29'h12A;       run("R6 masked", 2);
    slot_masked[1] = 0;     run("R6 exact rejects", 0);
    id_mask = '1; last_mask = 29'h700; slot_masked[1] = 1;
    slot_rdy[14] = 1; slot_masked[14] = 1; arb_a[14] = 29'h155;
    frm_id = 29'h1AA;       run("R6 slot15 own mask", 15);
  endtask

  task automatic t_ext();
    clear_cfg();
    slot_rdy[4] = 1; arb_a[4] = 29'h1ABCDE12;
    frm_ext = 1; frm_id = 29'h1ABCDE12;             run("R5 ext match", 5);
    frm_id = 29'h1ABCDE12 ^ 29'h10000000;           run("R5 ext bit28", 0);
    frm_ext = 0;                                    run("R5 std low only", 5);
  endtask

  task automatic t_data();
    clear_cfg();
    frm_id = 29'h0AB;
    slot_rdy[0] = 1; slot_dfilt[0] = 1; arb_a[0] = 29'h0AB;
    slot_rdy[5] = 1; arb_a[5] = 29'h0AB;
    med_arb0 = 8'hA5; med_mask0 = 8'hFF; med_arb1 = 8'h3C; med_mask1 = 8'hF0;
    frm_b0 = 8'hA5; frm_b1 = 8'h3F;  run("R7 bytes match", 1);
    frm_b1 = 8'h4C;                   run("R7 byte1 mismatch", 6);
    frm_b1 = 8'h3C; frm_b0 = 8'hA4;   run("R7 byte0 mismatch", 6);
    frm_b0 = 8'hA5; frm_dlc = 4'd1;   run("R7 short frame", 6);
    slot_dfilt[0] = 0; frm_dlc = 4'd0; frm_b0 = 8'h00;
    run("R7 filter off", 1);
  endtask

  task automatic t_hold();
    clear_cfg();
    slot_rdy[9] = 1; arb_a[9] = 29'h77; frm_id = 29'h77;
    run("R10 setup", 10);
    @(negedge clk) frm_id = 29'h78; slot_rdy = '0;
    repeat (3) @(negedge clk);
    check("R10 hit held", int'(res_hit), 1);
    check("R10 slot held", int'(res_slot), 10);
    check("R1 pulse ends", int'(res_valid), 0);
  endtask

  initial begin
    t_reset();
    t_exact_std();
    t_priority();
    t_masked();
    t_ext();
    t_data();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule